// File: doc/BRIEF.md
# Prefixed Instruction Opcode Classifier

This block sits in a byte-serial instruction front end. It accepts one instruction byte per cycle under a valid/ready handshake. It absorbs any run of legacy prefix bytes and records which prefixes occurred. It then identifies the opcode as one of the following: a no-operation, a forward or reverse bit scan, a leading- or trailing-zero count, or some other instruction. For each instruction it issues one result carrying the class, the prefix-seen mask and the instruction's byte count.

Some byte sequences give different instructions depending on the core generation. On older cores the repeat prefix 0xF3 has no effect in front of the bit-scan opcodes. Newer cores read that same combination as a zero-count instruction. The `countMode` input chooses which reading applies. The block also enforces the architectural length ceiling: an instruction that is still incomplete at its fifteenth byte is closed off with a fault flag, and the next byte starts a new instruction. Operand and displacement length decoding are not handled. The only exception is the single ModR/M byte that follows a bit-scan opcode.

Top module: `pfx_classifier`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `outValid` and returns the classifier to the first-byte state, even in the middle of an instruction. The byte accepted after reset is treated as the first byte of a new instruction with an empty prefix mask.
- R2: The recognised prefixes map to `outPrefixes` bits as follows: bit0 0xF0, bit1 0xF2, bit2 0xF3, bit3 0x2E, bit4 0x36, bit5 0x3E, bit6 0x26, bit7 0x64, bit8 0x65, bit9 0x66, bit10 0x67. Any number of prefixes, including repeats of one prefix, may come before the opcode. The mask reports each prefix seen in the current instruction and is empty at the start of every instruction.
- R3: Byte 0x90 in opcode position, after zero or more prefixes, gives class 1 (no-op). The reported length is the prefix count plus one.
- R4: The sequence 0x0F 0xBD then one ModR/M byte gives class 2 (reverse bit scan). The sequence 0x0F 0xBC then one ModR/M byte gives class 3 (forward bit scan). The reported length is the prefix count plus three.
- R5: With `countMode` high while the second opcode byte is accepted, and 0xF3 among the prefixes, 0x0F 0xBD gives class 4 (leading-zero count) and 0x0F 0xBC gives class 5 (trailing-zero count).
- R6: With `countMode` low, an 0xF3 prefix has no effect on the bit-scan opcodes: the class stays 2 or 3, and mask bit2 is still reported.
- R7: Prefixes other than 0xF3 never change the class of a bit-scan opcode, in either mode.
- R8: Any opcode byte other than a prefix, 0x90 or 0x0F completes the instruction at that byte with class 0 (other). After 0x0F, any second byte other than 0xBC or 0xBD completes it with class 0.
- R9: If the fifteenth byte of an instruction does not complete it, a result is issued with `outLenFault` high, class 0 and length 15. The following byte starts a new instruction. A complete instruction of exactly 15 bytes raises no fault.
- R10: `inReady` is always high. `outValid` is high for exactly one cycle, in the cycle after the final byte's accepting edge, and the result fields are valid during that cycle. It is low after every non-final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input byte is valid |
| inReady | output | 1 | Classifier accepts a byte (always high) |
| inByte | input | 8 | Instruction byte |
| countMode | input | 1 | 1: 0xF3 with a bit-scan opcode decodes as a zero count; 0: the prefix is ignored |
| outValid | output | 1 | One-cycle result strobe |
| outClass | output | 3 | 0 other, 1 no-op, 2 reverse scan, 3 forward scan, 4 leading-zero count, 5 trailing-zero count |
| outPrefixes | output | 11 | Prefix-seen mask for the finished instruction |
| outLength | output | 4 | Bytes consumed by the finished instruction |
| outLenFault | output | 1 | Instruction reached 15 bytes without completing |

## Verification
Every result is registered once. The class, mask, length and fault are therefore due exactly one cycle after the rising edge that accepts the final byte. The bench drives each byte on a falling edge and samples on the falling edge right after each accepting edge. A strobe seen after a non-final byte counts as an error. The bench then waits one more edge and confirms the strobe has dropped. Length-limit cases are built so that the fault must appear on the edge of the fifteenth byte. Each such case is followed at once by a short instruction, to show that counting restarts.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int NUM_PFX = 11;
  // bit i of the seen mask corresponds to byte PFX_TABLE[i*8 +: 8]
  localparam logic [NUM_PFX*8-1:0] PFX_TABLE = {
    8'h67, 8'h66, 8'h65, 8'h64, 8'h26, 8'h3E,
    8'h36, 8'h2E, 8'hF3, 8'hF2, 8'hF0};
  localparam int REP_IDX = 2;

  localparam logic [7:0] OP_ESC     = 8'h0F;
  localparam logic [7:0] OP_NOP     = 8'h90;
  localparam logic [7:0] OP_SCANFWD = 8'hBC;
  localparam logic [7:0] OP_SCANREV = 8'hBD;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_NOP     = 3'd1,
    CLS_SCANREV = 3'd2,
    CLS_SCANFWD = 3'd3,
    CLS_LEADZ   = 3'd4,
    CLS_TRAILZ  = 3'd5
  } clsT;

  typedef struct packed {
    logic take;   // byte accepted this cycle
    logic mark;   // byte is a prefix to record
    logic done;   // byte ends the instruction
    logic fault;  // ended by the length ceiling
    clsT  cls;    // class to report when done
  } strobeT;
endpackage

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       countMode,
  input  logic       isPrefix,
  input  logic       repSeen,
  input  logic       atLimit,
  output strobeT     strb
);
  typedef enum logic [1:0] {ST_LEAD, ST_ESC, ST_MODRM} stT;

  stT  stQ, stD;
  clsT pendQ, pendD;

  always_comb begin
    stD   = stQ;
    pendD = pendQ;
    strb  = '{take: 1'b0, mark: 1'b0, done: 1'b0, fault: 1'b0, cls: CLS_OTHER};
    strb.take = inValid;
    if (inValid) begin
      unique case (stQ)
        ST_LEAD: begin
          if (isPrefix) begin
            strb.mark = 1'b1;
          end else if (inByte == OP_NOP) begin
            strb.done = 1'b1;
            strb.cls  = CLS_NOP;
          end else if (inByte == OP_ESC) begin
            stD = ST_ESC;
          end else begin
            strb.done = 1'b1;
          end
        end
        ST_ESC: begin
          if (inByte == OP_SCANREV) begin
            pendD = (repSeen && countMode) ? CLS_LEADZ : CLS_SCANREV;
            stD   = ST_MODRM;
          end else if (inByte == OP_SCANFWD) begin
            pendD = (repSeen && countMode) ? CLS_TRAILZ : CLS_SCANFWD;
            stD   = ST_MODRM;
          end else begin
            strb.done = 1'b1;
          end
        end
        ST_MODRM: begin
          strb.done = 1'b1;
          strb.cls  = pendQ;
        end
        default: stD = ST_LEAD;
      endcase
      if (!strb.done && atLimit) begin
        strb.done  = 1'b1;
        strb.fault = 1'b1;
        strb.cls   = CLS_OTHER;
      end
      if (strb.done) stD = ST_LEAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ   <= ST_LEAD;
      pendQ <= CLS_OTHER;
    end else begin
      stQ   <= stD;
      pendQ <= pendD;
    end
  end

  AST_MODRM_FOLLOWS_ESC: assert property (@(posedge clk) disable iff (rst)
    stQ == ST_MODRM |-> $past(stQ) == ST_ESC); // R4
  AST_PEND_IS_SCAN: assert property (@(posedge clk) disable iff (rst)
    stQ == ST_MODRM |-> pendQ inside {CLS_SCANREV, CLS_SCANFWD, CLS_LEADZ, CLS_TRAILZ}); // R4
  AST_COUNT_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    (stQ == ST_MODRM && pendQ inside {CLS_LEADZ, CLS_TRAILZ}) |-> $past(countMode)); // R6
endmodule

// File: rtl/pfx_dpath.sv
module pfx_dpath
  import pfx_pkg::*;
#(
  parameter int MAX_LEN = 15,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         inByte,
  input  strobeT             strb,
  output logic               isPrefix,
  output logic               repSeen,
  output logic               atLimit,
  output logic               outValid,
  output clsT                outClass,
  output logic [NUM_PFX-1:0] outPrefixes,
  output logic [LEN_W-1:0]   outLength,
  output logic               outLenFault
);
  logic [NUM_PFX-1:0] hit;
  logic [NUM_PFX-1:0] seenQ;
  logic [NUM_PFX-1:0] seenNext;
  logic [LEN_W-1:0]   cntQ;

  for (genvar i = 0; i < NUM_PFX; i++) begin : g_pfx
    assign hit[i] = (inByte == PFX_TABLE[i*8 +: 8]);
  end

  assign isPrefix = |hit;
  assign repSeen  = seenQ[REP_IDX];
  assign atLimit  = (cntQ == LEN_W'(MAX_LEN - 1));
  assign seenNext = strb.mark ? (seenQ | hit) : seenQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenQ       <= '0;
      cntQ        <= '0;
      outValid    <= 1'b0;
      outClass    <= CLS_OTHER;
      outPrefixes <= '0;
      outLength   <= '0;
      outLenFault <= 1'b0;
    end else begin
      outValid <= strb.take && strb.done;
      if (strb.take) begin
        if (strb.done) begin
          outClass    <= strb.cls;
          outPrefixes <= seenNext;
          outLength   <= cntQ + 1'b1;
          outLenFault <= strb.fault;
          seenQ       <= '0;
          cntQ        <= '0;
        end else begin
          seenQ <= seenNext;
          cntQ  <= cntQ + 1'b1;
        end
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !outValid); // R1
  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (cntQ == '0 && seenQ == '0)); // R2
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outLength != '0 && outLength <= LEN_W'(MAX_LEN))); // R9
  AST_FAULT_AT_CEIL: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLenFault) |-> (outLength == LEN_W'(MAX_LEN) && outClass == CLS_OTHER)); // R9
  AST_COUNT_HAS_REP: assert property (@(posedge clk) disable iff (rst)
    (outValid && outClass inside {CLS_LEADZ, CLS_TRAILZ}) |-> outPrefixes[REP_IDX]); // R5
  AST_SCAN_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    (outValid && outClass inside {CLS_SCANREV, CLS_SCANFWD, CLS_LEADZ, CLS_TRAILZ})
      |-> outLength >= LEN_W'(3)); // R4
endmodule

// File: rtl/pfx_classifier.sv
module pfx_classifier
  import pfx_pkg::*;
#(
  parameter int MAX_LEN = 15,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [7:0]         inByte,
  input  logic               countMode,
  output logic               outValid,
  output logic [2:0]         outClass,
  output logic [NUM_PFX-1:0] outPrefixes,
  output logic [LEN_W-1:0]   outLength,
  output logic               outLenFault
);
  strobeT strb;
  logic   isPrefix;
  logic   repSeen;
  logic   atLimit;
  clsT    clsOut;

  assign inReady  = 1'b1;
  assign outClass = clsOut;

  pfx_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inByte    (inByte),
    .countMode (countMode),
    .isPrefix  (isPrefix),
    .repSeen   (repSeen),
    .atLimit   (atLimit),
    .strb      (strb)
  );

  pfx_dpath #(.MAX_LEN(MAX_LEN)) dpath_i (
    .clk         (clk),
    .rst         (rst),
    .inByte      (inByte),
    .strb        (strb),
    .isPrefix    (isPrefix),
    .repSeen     (repSeen),
    .atLimit     (atLimit),
    .outValid    (outValid),
    .outClass    (clsOut),
    .outPrefixes (outPrefixes),
    .outLength   (outLength),
    .outLenFault (outLenFault)
  );
endmodule

// File: tb/pfx_classifier_tb_top.sv
`timescale 1ns/1ps
module pfx_classifier_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inByte = 8'h00;
  logic        countMode = 1'b0;
  logic        outValid;
  logic [2:0]  outClass;
  logic [10:0] outPrefixes;
  logic [3:0]  outLength;
  logic        outLenFault;

  int checks = 0;
  int errors = 0;
  logic [7:0] seq [16];
  logic [7:0] pfxCode [11] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                               8'h26, 8'h64, 8'h65, 8'h66, 8'h67};

  always #4 clk = ~clk;

  pfx_classifier dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inByte(inByte), .countMode(countMode), .outValid(outValid),
    .outClass(outClass), .outPrefixes(outPrefixes), .outLength(outLength),
    .outLenFault(outLenFault)
  );

  function automatic bit isPfx(input logic [7:0] b);
    for (int i = 0; i < 11; i++) if (pfxCode[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic runSeq(input int n, input logic mode, input int expCls,
                        input logic [10:0] expPfx, input int expLen,
                        input logic expFault, input string req);
    logic early;
    early = 1'b0;
    countMode = mode;
    for (int k = 0; k < n; k++) begin
      inValid = 1'b1;
      inByte  = seq[k];
      @(posedge clk);
      @(negedge clk);
      if (k < n - 1 && outValid) early = 1'b1;
    end
    inValid = 1'b0;
    checks++;
    if (early || !outValid || outClass != expCls[2:0] || outPrefixes != expPfx ||
        outLength != expLen[3:0] || outLenFault != expFault) begin
      errors++;
      $display("FAIL %s: valid=%0b early=%0b cls=%0d pfx=%03h len=%0d flt=%0b expected cls=%0d pfx=%03h len=%0d flt=%0b",
               req, outValid, early, outClass, outPrefixes, outLength, outLenFault,
               expCls, expPfx, expLen, expFault);
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid) begin
      errors++;
      $display("FAIL R10: strobe still high one cycle later, actual 1 expected 0");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired, actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] m;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R1: valid=%0b ready=%0b expected valid=0 ready=1", outValid, inReady);
    end

    // R3 no-op after 0..14 mixed prefixes; R2 mask
    for (int n = 0; n <= 14; n++) begin
      m = '0;
      for (int j = 0; j < n; j++) begin
        seq[j] = pfxCode[j % 11];
        m[j % 11] = 1'b1;
      end
      seq[n] = 8'h90;
      runSeq(n + 1, n[0], 1, m, n + 1, 1'b0, "R3 nop mixed prefixes");
    end

    // R2 each prefix repeated fourteen times
    for (int i = 0; i < 11; i++) begin
      for (int j = 0; j < 14; j++) seq[j] = pfxCode[i];
      seq[14] = 8'h90;
      runSeq(15, 1'b0, 1, 11'(1) << i, 15, 1'b0, "R2 repeated prefix");
    end

    // R4 plain bit scans
    for (int op = 0; op < 2; op++) begin
      seq[0] = 8'h0F; seq[1] = op ? 8'hBD : 8'hBC; seq[2] = 8'hC1;
      runSeq(3, 1'b1, op ? 2 : 3, '0, 3, 1'b0, "R4 bare bit scan");
    end

    // R5/R6/R7 every single prefix, both modes, both opcodes
    for (int i = 0; i < 11; i++) begin
      for (int md = 0; md < 2; md++) begin
        for (int op = 0; op < 2; op++) begin
          int e;
          seq[0] = pfxCode[i]; seq[1] = 8'h0F; seq[2] = op ? 8'hBD : 8'hBC; seq[3] = 8'h05;
          if (i == 2 && md == 1) begin
            e = op ? 4 : 5;
            runSeq(4, 1'b1, e, 11'(1) << i, 4, 1'b0, "R5 repurposed count");
          end else if (i == 2) begin
            e = op ? 2 : 3;
            runSeq(4, 1'b0, e, 11'(1) << i, 4, 1'b0, "R6 legacy ignores F3");
          end else begin
            e = op ? 2 : 3;
            runSeq(4, md[0], e, 11'(1) << i, 4, 1'b0, "R7 other prefix no effect");
          end
        end
      end
    end

    // R5 boundary: 12 prefixes plus 3 opcode bytes equals 15
    seq[0] = 8'hF3;
    for (int j = 1; j < 12; j++) seq[j] = 8'h66;
    seq[12] = 8'h0F; seq[13] = 8'hBD; seq[14] = 8'h00;
    runSeq(15, 1'b1, 4, 11'h204, 15, 1'b0, "R5 count at 15 bytes");
    runSeq(15, 1'b0, 2, 11'h204, 15, 1'b0, "R6 legacy at 15 bytes");

    // R8 every one-byte opcode
    for (int b = 0; b < 256; b++) begin
      if (!isPfx(8'(b)) && b != 8'h0F) begin
        seq[0] = 8'(b);
        runSeq(1, 1'b0, (b == 8'h90) ? 1 : 0, '0, 1, 1'b0, "R8 single-byte opcode");
      end
    end

    // R8 every escape second byte
    for (int b = 0; b < 256; b++) begin
      if (b != 8'hBC && b != 8'hBD) begin
        seq[0] = 8'h0F; seq[1] = 8'(b);
        runSeq(2, 1'b1, 0, '0, 2, 1'b0, "R8 escape other");
      end
    end

    // R9 fifteen prefixes
    for (int j = 0; j < 15; j++) seq[j] = 8'h66;
    runSeq(15, 1'b0, 0, 11'h200, 15, 1'b1, "R9 prefix overrun");
    seq[0] = 8'h90;
    runSeq(1, 1'b0, 1, '0, 1, 1'b0, "R9 restart after fault");

    // R9 bit scan missing its ModR/M at the ceiling
    for (int j = 0; j < 13; j++) seq[j] = 8'hF3;
    seq[13] = 8'h0F; seq[14] = 8'hBD;
    runSeq(15, 1'b1, 0, 11'h004, 15, 1'b1, "R9 scan overrun");
    seq[0] = 8'hC1;
    runSeq(1, 1'b1, 0, '0, 1, 1'b0, "R9 next byte not ModR/M");

    // R9 escape byte at the ceiling
    for (int j = 0; j < 14; j++) seq[j] = 8'h2E;
    seq[14] = 8'h0F;
    runSeq(15, 1'b0, 0, 11'h008, 15, 1'b1, "R9 escape overrun");

    // R1 reset mid-instruction
    countMode = 1'b1;
    inValid = 1'b1; inByte = 8'hF3;
    @(posedge clk); @(negedge clk);
    inByte = 8'h0F;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid after reset actual %0b expected 0", outValid);
    end
    seq[0] = 8'hBD;
    runSeq(1, 1'b1, 0, '0, 1, 1'b0, "R1 reset discards partial");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule